// File: doc/BRIEF.md
# Serial Transmit Interrupt Source Selector

This block produces the single transmit interrupt of a synchronous serial port. A two-bit mode register picks which of four events raises it. The four events are a rise of the transmit-ready flag, a crossing of a 16-channel block boundary (or the end of the frame) while multichannel selection is active, a transmit frame-sync pulse, and a rise of the frame-sync error flag. The result is a single-cycle pulse in the CPU clock domain.

The frame-sync input arrives from the serial clock domain and is treated as asynchronous. It passes through a two-flop synchronizer and a rising-edge detector. Frame-sync interrupts therefore still reach the CPU while the transmitter is held in reset. The other three causes are held off during transmitter reset. Every edge detector keeps its history in all modes, so changing the mode never creates an interrupt by itself.

Top module: `tx_irq_select`

## Requirements
- R1: The mode register is 2 bits wide and resets to 00. It is loaded from `mode_wdata` on a clock edge where `mode_wr` is 1, and it is visible on `mode_rdata`. A new value governs event selection starting with the next clock edge.
- R2: In mode 00, when `tx_ready` is sampled 1 at an edge after being sampled 0 at the previous edge, `irq` is 1 for the cycle after that edge. `tx_ready` is taken to be 0 before reset.
- R3: In mode 01 with `mc_en` at 1, a sampled `chan_step` pulses `irq` in the next cycle in either of two cases. One case is that the low 4 bits of `chan_idx` are 1111, which closes a 16-channel block. The other case is that `frame_last` is 1. When both are true at once, there is one pulse.
- R4: In mode 01 with `mc_en` at 0, `irq` stays 0 whatever the channel inputs do.
- R5: In mode 10, when `fsync_raw` is sampled 1 at edge E after being 0 at edge E-1, `irq` is 1 for exactly the one cycle that follows edge E+2.
- R6: While `tx_reset` is 1, modes 00, 01 and 11 give no interrupt. Mode 10 still gives its interrupts.
- R7: In mode 11, when `sync_err` is sampled 1 after being 0 at the previous edge, `irq` pulses in the next cycle.
- R8: `sync_err_flag` shows `sync_err` in every mode.
- R9: Each event gives exactly one single-cycle pulse. A source that stays high does not trigger again.
- R10: Edge histories update in every mode. Writing a new mode while the newly selected source is already high gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 2 | New mode value |
| mode_rdata | output | 2 | Current mode value |
| tx_ready | input | 1 | Transmit-ready flag |
| fsync_raw | input | 1 | Asynchronous transmit frame-sync input |
| chan_step | input | 1 | One-cycle strobe marking the end of a channel slot |
| chan_idx | input | CH_W | Index of the slot that is ending |
| frame_last | input | 1 | The slot that is ending is the last one of the frame |
| mc_en | input | 1 | Multichannel selection active |
| sync_err | input | 1 | Frame-sync error flag |
| tx_reset | input | 1 | Transmitter held in reset |
| sync_err_flag | output | 1 | Software-readable copy of the error flag |
| irq | output | 1 | Single-cycle transmit interrupt |

## Verification
The frame-sync path runs three cycles behind its input, while the other sources respond in one cycle. So a frame-sync edge and a mode write can arrive in the same cycle, and so can the end of the frame and a block boundary. The random phase toggles `fsync_raw`, `tx_reset` and the mode register independently, which makes them collide often. Directed steps place a frame-sync edge right beside a mode switch and put `frame_last` on slot 15. Each cycle's `irq` is judged against a bench model that applies the selection rule to the mode in force at that edge.

// File: rtl/tx_irq_pkg.sv
// Shared types for the transmit interrupt selector.
// Assumes: the mode encoding is fixed by software and must not change.
package tx_irq_pkg;
    typedef enum logic [1:0] {
        SRC_READY = 2'b00,
        SRC_BLOCK = 2'b01,
        SRC_FSYNC = 2'b10,
        SRC_ERROR = 2'b11
    } irq_src_t;
endpackage

// File: rtl/tx_irq_edge.sv
// Rising-edge detector with one history flop.
// Assumes: d is already synchronous to clk; history resets to 0.
module tx_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise
);
    logic hist_q;

    // Keep last sampled level, in every mode
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= d;
    end

    assign rise = d & ~hist_q;
endmodule

// File: rtl/tx_irq_sync.sv
// Multi-stage synchronizer for an asynchronous level.
// Assumes: STAGES >= 2; the input is held long enough to be sampled.
module tx_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/tx_irq_block.sv
// Block-boundary detector for multichannel transmit.
// Assumes: chan_step is a one-cycle strobe carrying the index of the
// slot that is ending; a block spans 2**BLK_W channels.
module tx_irq_block #(
    parameter int CH_W  = 7,
    parameter int BLK_W = 4
) (
    input  logic            chan_step,
    input  logic [CH_W-1:0] chan_idx,
    input  logic            frame_last,
    input  logic            mc_en,
    output logic            blk_evt
);
    localparam logic [BLK_W-1:0] LAST_IN_BLK = '1;

    logic at_boundary;

    // Slot index closes a block when its low bits are all ones
    always_comb begin
        at_boundary = (chan_idx[BLK_W-1:0] == LAST_IN_BLK);
    end

    // Qualify by strobe and multichannel mode; end of frame also counts
    always_comb begin
        blk_evt = mc_en & chan_step & (at_boundary | frame_last);
    end
endmodule

// File: rtl/tx_irq_select.sv
// Transmit interrupt source selector: four causes, one pulsed output.
// Assumes: fsync_raw is asynchronous, all other inputs are synchronous
// to clk; the mode register is written through mode_wr/mode_wdata.
module tx_irq_select
    import tx_irq_pkg::*;
#(
    parameter int CH_W        = 7,
    parameter int BLK_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_wr,
    input  logic [1:0]      mode_wdata,
    output logic [1:0]      mode_rdata,
    input  logic            tx_ready,
    input  logic            fsync_raw,
    input  logic            chan_step,
    input  logic [CH_W-1:0] chan_idx,
    input  logic            frame_last,
    input  logic            mc_en,
    input  logic            sync_err,
    input  logic            tx_reset,
    output logic            sync_err_flag,
    output logic            irq
);
    irq_src_t mode_q;
    logic     fsync_s;
    logic     rdy_rise, fs_rise, err_rise, blk_evt;
    logic     sel_evt;
    logic     irq_q;

    // Mode register, reset to the ready-flag source
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= SRC_READY;
        else if (mode_wr) mode_q <= irq_src_t'(mode_wdata);
    end

    tx_irq_sync #(.STAGES(SYNC_STAGES)) u_fs_sync (
        .clk(clk), .rst_n(rst_n), .async_in(fsync_raw), .sync_out(fsync_s)
    );

    tx_irq_edge u_rdy_edge (.clk(clk), .rst_n(rst_n), .d(tx_ready), .rise(rdy_rise));
    tx_irq_edge u_fs_edge  (.clk(clk), .rst_n(rst_n), .d(fsync_s),  .rise(fs_rise));
    tx_irq_edge u_err_edge (.clk(clk), .rst_n(rst_n), .d(sync_err), .rise(err_rise));

    tx_irq_block #(.CH_W(CH_W), .BLK_W(BLK_W)) u_block (
        .chan_step(chan_step), .chan_idx(chan_idx), .frame_last(frame_last),
        .mc_en(mc_en), .blk_evt(blk_evt)
    );

    // Pick the event for the active mode; only frame sync survives tx reset
    always_comb begin
        unique case (mode_q)
            SRC_READY: sel_evt = rdy_rise & ~tx_reset;
            SRC_BLOCK: sel_evt = blk_evt  & ~tx_reset;
            SRC_FSYNC: sel_evt = fs_rise;
            SRC_ERROR: sel_evt = err_rise & ~tx_reset;
            default:   sel_evt = 1'b0;
        endcase
    end

    // Register the pulse so the interrupt line is glitch-free
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= sel_evt;
    end

    assign irq           = irq_q;
    assign mode_rdata    = mode_q;
    assign sync_err_flag = sync_err;
endmodule

// File: rtl/tx_irq_select_chk.sv
// Property checker for tx_irq_select, attached with bind below.
// Assumes: only top-level ports are observed.
module tx_irq_select_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_wr,
    input logic [1:0] mode_rdata,
    input logic       tx_ready,
    input logic       chan_step,
    input logic       mc_en,
    input logic       sync_err,
    input logic       tx_reset,
    input logic       irq
);
    assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mode_wr) |-> mode_rdata == $past(mode_rdata));

    assert_ready_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(mode_rdata) == 2'b00) |-> $past(tx_ready));

    assert_block_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(mode_rdata) == 2'b01) |-> $past(chan_step));

    assert_no_mc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_rdata) == 2'b01 && !$past(mc_en)) |-> !irq);

    assert_reset_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_reset) && $past(mode_rdata) != 2'b10) |-> !irq);

    assert_error_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(mode_rdata) == 2'b11) |-> $past(sync_err));
endmodule

bind tx_irq_select tx_irq_select_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_rdata(mode_rdata),
    .tx_ready(tx_ready), .chan_step(chan_step), .mc_en(mc_en),
    .sync_err(sync_err), .tx_reset(tx_reset), .irq(irq)
);

// File: tb/sim_tx_irq_select.sv
module sim_tx_irq_select;
    localparam int CH_W = 7;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            mode_wr;
    logic [1:0]      mode_wdata;
    logic [1:0]      mode_rdata;
    logic            tx_ready, fsync_raw, chan_step, frame_last, mc_en;
    logic [CH_W-1:0] chan_idx;
    logic            sync_err, tx_reset, sync_err_flag, irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // model state
    logic [1:0] m_mode;
    logic m_rdy, m_s1, m_s2, m_s3, m_err;

    always #5 clk = ~clk;

    tx_irq_select #(.CH_W(CH_W)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .mode_rdata(mode_rdata), .tx_ready(tx_ready), .fsync_raw(fsync_raw),
        .chan_step(chan_step), .chan_idx(chan_idx), .frame_last(frame_last),
        .mc_en(mc_en), .sync_err(sync_err), .tx_reset(tx_reset),
        .sync_err_flag(sync_err_flag), .irq(irq)
    );

    function automatic string req_of(input logic [1:0] m);
        case (m)
            2'b00: return "R2";
            2'b01: return "R3/R4";
            2'b10: return "R5/R6";
            default: return "R7";
        endcase
    endfunction

    // Expected irq after the next edge, from the selection rules
    function automatic logic exp_irq();
        logic ev_rdy, ev_fs, ev_err, ev_blk;
        ev_rdy = tx_ready & ~m_rdy;
        ev_fs  = m_s2 & ~m_s3;
        ev_err = sync_err & ~m_err;
        ev_blk = mc_en & chan_step & ((chan_idx[3:0] == 4'hF) | frame_last);
        case (m_mode)
            2'b00:   return ev_rdy & ~tx_reset;
            2'b01:   return ev_blk & ~tx_reset;
            2'b10:   return ev_fs;
            default: return ev_err & ~tx_reset;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock step: predict, advance model, sample at negedge
    task automatic step();
        logic e;
        string r;
        r = req_of(m_mode);
        e = exp_irq();
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = fsync_raw;
        m_rdy = tx_ready; m_err = sync_err;
        if (mode_wr) m_mode = mode_wdata;
        @(posedge clk);
        @(negedge clk);
        check(irq == e, r, irq, e);
        check(mode_rdata == m_mode, "R1", mode_rdata, m_mode);
        check(sync_err_flag == sync_err, "R8", sync_err_flag, sync_err);
        mode_wr = 1'b0;
        chan_step = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_wr = 1'b1; mode_wdata = m;
        step();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        rst_n = 1'b0; mode_wr = 1'b0; mode_wdata = 2'b00;
        tx_ready = 1'b0; fsync_raw = 1'b0; chan_step = 1'b0; chan_idx = '0;
        frame_last = 1'b0; mc_en = 1'b0; sync_err = 1'b0; tx_reset = 1'b0;
        m_mode = 2'b00; m_rdy = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // reset state R1
        check(mode_rdata == 2'b00, "R1", mode_rdata, 0);
        check(irq == 1'b0, "R9", irq, 0);

        // R2 / R9: rise then held level gives one pulse
        tx_ready = 1'b1;
        repeat (5) step();
        tx_ready = 1'b0; step();

        // R10: switch to error mode with sync_err already high
        sync_err = 1'b1; step(); step();
        set_mode(2'b11);
        repeat (3) step();
        sync_err = 1'b0; step();
        sync_err = 1'b1; step(); step();   // R7 pulse
        sync_err = 1'b0;

        // R3: block boundary and frame end on slot 15 together, then R4
        set_mode(2'b01);
        mc_en = 1'b1;
        for (int i = 0; i < 40; i++) begin
            chan_step = 1'b1; chan_idx = CH_W'(i); frame_last = (i == 15) || (i == 39);
            step();
        end
        mc_en = 1'b0;
        for (int i = 0; i < 20; i++) begin
            chan_step = 1'b1; chan_idx = CH_W'(i); frame_last = (i == 19);
            step();
        end
        frame_last = 1'b0;

        // R5 / R6: frame sync while transmitter reset, mode write beside edge
        set_mode(2'b10);
        tx_reset = 1'b1;
        fsync_raw = 1'b1; repeat (4) step();
        fsync_raw = 1'b0; step();
        fsync_raw = 1'b1; mode_wr = 1'b1; mode_wdata = 2'b00; step();
        fsync_raw = 1'b0; repeat (4) step();
        tx_reset = 1'b0;

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 3) == 0) tx_ready  = ~tx_ready;
            if ($urandom_range(0, 3) == 0) fsync_raw = ~fsync_raw;
            if ($urandom_range(0, 4) == 0) sync_err  = ~sync_err;
            if ($urandom_range(0, 15) == 0) tx_reset = ~tx_reset;
            if ($urandom_range(0, 31) == 0) mc_en    = ~mc_en;
            if ($urandom_range(0, 24) == 0) begin
                mode_wr = 1'b1; mode_wdata = 2'($urandom_range(0, 3));
            end
            chan_step  = ($urandom_range(0, 1) == 0);
            chan_idx   = CH_W'($urandom_range(0, 127));
            frame_last = ($urandom_range(0, 7) == 0);
            step();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule